// File: doc/BRIEF.md
# Model-Gated Control Register File

This block holds the supervisor control registers of a legacy CISC processor core and serves the two opcodes that move data between a general register and a control register. The pipeline presents each access as one instruction word, a 12-bit register code and a 32-bit write value. A static input selects which processor generation the core emulates. The block answers in the same cycle. Either the transfer completes (`done`), or the access is refused (`illegal`) and the exception logic upstream takes over.

Each register exists on only some generations, so every access is checked against the selected one. A refused access changes nothing and reads as zero. Generation 0 has no control-register move at all. The cache control register keeps only the bits that the selected generation implements. Privilege checks, exception vectoring and the effects of these registers on translation, caching and stack selection belong to other blocks.

Generation codes on `cpu_model`: 0 is the base generation, 1 adds the move instruction, 2 and 3 add cache control and the master/interrupt stacks, 4 adds paged translation and transparent windows, and 5 is the late generation. Codes 6 and 7 name no supported generation.

Top module: `ctlreg_bank`

## Requirements
- R1: An access is recognised only when `acc_valid` is 1 and `acc_opcode` AND 0xFFFE equals 0x4E7A. Opcode bit 0 = 1 writes the control register and bit 0 = 0 reads it. Any other word, or `acc_valid` = 0, gives `done` = 0, `illegal` = 0 and `rd_data` = 0, and changes no register.
- R2: With `cpu_model` = 0, every recognised access is illegal.
- R3: Codes 0x000 (source function code), 0x001 (destination function code), 0x800 (user stack) and 0x801 (vector base) are legal in both directions on models 1 to 5.
- R4: Code 0x002 (cache control) is legal on models 2 to 5 and illegal on model 1.
- R5: A write to code 0x002 stores the value AND 0x80008000 on model 4 and AND 0xF8E0E000 on model 5. On models 2 and 3 it stores the value unmasked.
- R6: Codes 0x003 (translation control), 0x806 (user root) and 0x807 (supervisor root) are legal only on models 4 and 5.
- R7: Code 0x805 (translation status) is legal only on model 4.
- R8: Codes 0x803 (master stack) and 0x804 (interrupt stack) are legal only on models 2, 3 and 4.
- R9: Codes 0x004 to 0x007 (two instruction and two data transparent windows) are legal only on model 4.
- R10: Codes 0x008, 0x802, 0x808 and every unlisted code are illegal on every model. Every access is illegal when `cpu_model` is 6 or 7.
- R11: A recognised illegal access gives `illegal` = 1 and `done` = 0 in that cycle, `rd_data` = 0, and no register change. A legal access gives `done` = 1 and `illegal` = 0.
- R12: A legal read returns the stored value on `rd_data` in the access cycle. A legal write takes effect at the clock edge that ends the access cycle. `rd_data` is 0 during a write.
- R13: A synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An instruction access is presented this cycle |
| acc_opcode | input | 16 | Instruction word of the access |
| acc_code | input | 12 | Control register code |
| acc_wdata | input | 32 | Value to write |
| cpu_model | input | 3 | Selected processor generation, 0 to 5 |
| rd_data | output | 32 | Read value, zero unless a legal read |
| illegal | output | 1 | Illegal-instruction pulse for this access |
| done | output | 1 | Access completed this cycle |

## Verification
The hardest part to observe is the promise that a refused write leaves storage alone. Registers can only be read back through a model that permits them, and that model must differ from the one under which the write was refused. The stimulus therefore changes `cpu_model` from one access to the next. It writes a register under a permitting generation, tries a write under a refusing one, and then reads the register back under a permitting generation. Cache-control masking is checked the same way, through a write and read-back pair on each generation that provides the register.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int CR_DW   = 32;
    localparam int CR_CW   = 12;
    localparam int CR_OPW  = 16;
    localparam int CR_NUM  = 15;
    localparam int CR_IDW  = $clog2(CR_NUM + 1);

    localparam logic [CR_OPW-1:0] MOVE_OPC  = 16'h4E7A;
    localparam logic [CR_OPW-1:0] MOVE_MASK = 16'hFFFE;

    localparam logic [CR_DW-1:0] CACHE_MASK_G4 = 32'h8000_8000;
    localparam logic [CR_DW-1:0] CACHE_MASK_G5 = 32'hF8E0_E000;

    typedef enum logic [CR_IDW-1:0] {
        CR_FCS    = 4'd0,
        CR_FCD    = 4'd1,
        CR_CACHE  = 4'd2,
        CR_XLAT   = 4'd3,
        CR_ITW0   = 4'd4,
        CR_ITW1   = 4'd5,
        CR_DTW0   = 4'd6,
        CR_DTW1   = 4'd7,
        CR_USP    = 4'd8,
        CR_VBASE  = 4'd9,
        CR_MSP    = 4'd10,
        CR_ISP    = 4'd11,
        CR_XSTAT  = 4'd12,
        CR_UROOT  = 4'd13,
        CR_SROOT  = 4'd14,
        CR_NONE   = 4'd15
    } cr_id_e;

    typedef struct packed {
        logic   hit;
        logic   wr;
        cr_id_e id;
    } cr_req_t;

    function automatic cr_id_e cr_lookup(input logic [CR_CW-1:0] code);
        cr_id_e r;
        case (code)
            12'h000: r = CR_FCS;
            12'h001: r = CR_FCD;
            12'h002: r = CR_CACHE;
            12'h003: r = CR_XLAT;
            12'h004: r = CR_ITW0;
            12'h005: r = CR_ITW1;
            12'h006: r = CR_DTW0;
            12'h007: r = CR_DTW1;
            12'h800: r = CR_USP;
            12'h801: r = CR_VBASE;
            12'h803: r = CR_MSP;
            12'h804: r = CR_ISP;
            12'h805: r = CR_XSTAT;
            12'h806: r = CR_UROOT;
            12'h807: r = CR_SROOT;
            default: r = CR_NONE;
        endcase
        return r;
    endfunction

    function automatic logic cr_allowed(input cr_id_e id, input logic [2:0] gen);
        logic g15, g25, g24, g45, g4, ok;
        g15 = (gen >= 3'd1) && (gen <= 3'd5);
        g25 = (gen >= 3'd2) && (gen <= 3'd5);
        g24 = (gen >= 3'd2) && (gen <= 3'd4);
        g45 = (gen == 3'd4) || (gen == 3'd5);
        g4  = (gen == 3'd4);
        case (id)
            CR_FCS, CR_FCD, CR_USP, CR_VBASE:  ok = g15;
            CR_CACHE:                          ok = g25;
            CR_XLAT, CR_UROOT, CR_SROOT:       ok = g45;
            CR_XSTAT:                          ok = g4;
            CR_ITW0, CR_ITW1, CR_DTW0, CR_DTW1: ok = g4;
            CR_MSP, CR_ISP:                    ok = g24;
            default:                           ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [CR_DW-1:0] cache_wmask(input logic [2:0] gen);
        logic [CR_DW-1:0] m;
        case (gen)
            3'd4:    m = CACHE_MASK_G4;
            3'd5:    m = CACHE_MASK_G5;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int OPW = CR_OPW,
    parameter int CW  = CR_CW
) (
    input  logic           valid,
    input  logic [OPW-1:0] opcode,
    input  logic [CW-1:0]  code,
    output cr_req_t        req
);
    // The pair of move opcodes differs only in bit 0, which picks direction.
    always_comb begin
        req.hit = valid && ((opcode & MOVE_MASK) == MOVE_OPC);
        req.wr  = opcode[0];
        req.id  = cr_lookup(code);
    end
endmodule

// File: rtl/ctlreg_gate.sv
module ctlreg_gate
    import ctlreg_pkg::*;
(
    input  cr_req_t    req,
    input  logic [2:0] gen,
    output logic       pass,
    output logic       fault
);
    logic allow;

    always_comb begin
        allow = cr_allowed(req.id, gen);
        pass  = req.hit && allow;
        fault = req.hit && !allow;
    end
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter int DW = CR_DW,
    parameter int N  = CR_NUM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  cr_id_e        id,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    gen,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] bank [N];
    logic [DW-1:0] wval;

    // Cache control keeps only the bits the selected generation implements.
    always_comb begin
        if (id == CR_CACHE) wval = wdata & cache_wmask(gen);
        else                wval = wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (id == cr_id_e'(CR_IDW'(i))))
                q <= wval;
        end
        assign bank[i] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (id == cr_id_e'(CR_IDW'(i))) rdata = bank[i];
        end
    end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter int DW  = CR_DW,
    parameter int CW  = CR_CW,
    parameter int OPW = CR_OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_valid,
    input  logic [OPW-1:0] acc_opcode,
    input  logic [CW-1:0]  acc_code,
    input  logic [DW-1:0]  acc_wdata,
    input  logic [2:0]     cpu_model,
    output logic [DW-1:0]  rd_data,
    output logic           illegal,
    output logic           done
);
    cr_req_t       req;
    logic          pass;
    logic          fault;
    logic [DW-1:0] slot_rd;

    ctlreg_decode #(.OPW(OPW), .CW(CW)) u_dec (
        .valid  (acc_valid),
        .opcode (acc_opcode),
        .code   (acc_code),
        .req    (req)
    );

    ctlreg_gate u_gate (
        .req   (req),
        .gen   (cpu_model),
        .pass  (pass),
        .fault (fault)
    );

    ctlreg_store #(.DW(DW), .N(CR_NUM)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (pass && req.wr),
        .id    (req.id),
        .wdata (acc_wdata),
        .gen   (cpu_model),
        .rdata (slot_rd)
    );

    assign done    = pass;
    assign illegal = fault;
    assign rd_data = (pass && !req.wr) ? slot_rd : '0;
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [15:0] acc_opcode,
    input logic [11:0] acc_code,
    input logic [2:0]  cpu_model,
    input logic [31:0] rd_data,
    input logic        illegal,
    input logic        done
);
    logic is_move;
    assign is_move = acc_valid && (acc_opcode[15:1] == 15'h273D);

    // R11: an access never both completes and faults
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(illegal && done));

    // R1: responses only for a recognised move
    p_only_move_r1: assert property (@(posedge clk) disable iff (rst)
        (illegal || done) |-> is_move);

    // R2: base generation refuses everything
    p_base_gen_r2: assert property (@(posedge clk) disable iff (rst)
        (is_move && cpu_model == 3'd0) |-> illegal);

    // R11: a refused access reads as zero
    p_fault_zero_r11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (rd_data == 32'h0));

    // R10: unimplemented codes refused on any model
    p_unimpl_r10: assert property (@(posedge clk) disable iff (rst)
        (is_move && (acc_code == 12'h808 || acc_code == 12'h802 || acc_code == 12'h008))
        |-> illegal);

    // R5: a generation-4 cache write followed by a read shows only masked bits
    p_cache_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !acc_opcode[0] && acc_code == 12'h002 &&
         $past(done && acc_opcode[0] && acc_code == 12'h002 && cpu_model == 3'd4))
        |-> ((rd_data & ~32'h8000_8000) == 32'h0));
endmodule

bind ctlreg_bank ctlreg_bank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_opcode (acc_opcode),
    .acc_code   (acc_code),
    .cpu_model  (cpu_model),
    .rd_data    (rd_data),
    .illegal    (illegal),
    .done       (done)
);

// File: tb/ctlreg_bank_tb.sv
module ctlreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_opcode = 16'h0;
    logic [11:0] acc_code = 12'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic [2:0]  cpu_model = 3'd0;
    logic [31:0] rd_data;
    logic        illegal;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ctlreg_bank u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_opcode(acc_opcode),
        .acc_code(acc_code), .acc_wdata(acc_wdata), .cpu_model(cpu_model),
        .rd_data(rd_data), .illegal(illegal), .done(done)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] code;
        logic [31:0] wd;
        logic [2:0]  model;
        logic        ill;
        logic [31:0] rd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h000, 32'h1111_1111, 3'd1, 1'b0, 32'h0, 4'd3},          // R3
        '{1'b0, 12'h000, 32'h0, 3'd1, 1'b0, 32'h1111_1111, 4'd3},          // R3
        '{1'b0, 12'h002, 32'h0, 3'd1, 1'b1, 32'h0, 4'd4},                  // R4
        '{1'b1, 12'h002, 32'hFFFF_FFFF, 3'd2, 1'b0, 32'h0, 4'd4},          // R4
        '{1'b0, 12'h002, 32'h0, 3'd2, 1'b0, 32'hFFFF_FFFF, 4'd5},          // R5
        '{1'b1, 12'h002, 32'hFFFF_FFFF, 3'd4, 1'b0, 32'h0, 4'd5},          // R5
        '{1'b0, 12'h002, 32'h0, 3'd4, 1'b0, 32'h8000_8000, 4'd5},          // R5
        '{1'b1, 12'h002, 32'hFFFF_FFFF, 3'd5, 1'b0, 32'h0, 4'd5},          // R5
        '{1'b0, 12'h002, 32'h0, 3'd5, 1'b0, 32'hF8E0_E000, 4'd5},          // R5
        '{1'b1, 12'h003, 32'hA5A5_A5A5, 3'd5, 1'b0, 32'h0, 4'd6},          // R6
        '{1'b0, 12'h003, 32'h0, 3'd5, 1'b0, 32'hA5A5_A5A5, 4'd6},          // R6
        '{1'b0, 12'h003, 32'h0, 3'd3, 1'b1, 32'h0, 4'd6},                  // R6
        '{1'b1, 12'h003, 32'h1234_5678, 3'd3, 1'b1, 32'h0, 4'd11},         // R11
        '{1'b0, 12'h003, 32'h0, 3'd5, 1'b0, 32'hA5A5_A5A5, 4'd11},         // R11
        '{1'b1, 12'h805, 32'hCAFE_0001, 3'd4, 1'b0, 32'h0, 4'd7},          // R7
        '{1'b0, 12'h805, 32'h0, 3'd5, 1'b1, 32'h0, 4'd7},                  // R7
        '{1'b0, 12'h805, 32'h0, 3'd4, 1'b0, 32'hCAFE_0001, 4'd7},          // R7
        '{1'b1, 12'h803, 32'h0000_0400, 3'd2, 1'b0, 32'h0, 4'd8},          // R8
        '{1'b0, 12'h803, 32'h0, 3'd5, 1'b1, 32'h0, 4'd8},                  // R8
        '{1'b0, 12'h803, 32'h0, 3'd3, 1'b0, 32'h0000_0400, 4'd8},          // R8
        '{1'b1, 12'h804, 32'h0000_BEEF, 3'd4, 1'b0, 32'h0, 4'd8},          // R8
        '{1'b1, 12'h804, 32'h0000_0001, 3'd1, 1'b1, 32'h0, 4'd8},          // R8
        '{1'b0, 12'h804, 32'h0, 3'd4, 1'b0, 32'h0000_BEEF, 4'd8},          // R8
        '{1'b1, 12'h006, 32'h0F0F_0000, 3'd4, 1'b0, 32'h0, 4'd9},          // R9
        '{1'b0, 12'h006, 32'h0, 3'd5, 1'b1, 32'h0, 4'd9},                  // R9
        '{1'b0, 12'h006, 32'h0, 3'd4, 1'b0, 32'h0F0F_0000, 4'd9},          // R9
        '{1'b1, 12'h807, 32'h0000_1000, 3'd4, 1'b0, 32'h0, 4'd6},          // R6
        '{1'b0, 12'h807, 32'h0, 3'd5, 1'b0, 32'h0000_1000, 4'd6},          // R6
        '{1'b0, 12'h806, 32'h0, 3'd2, 1'b1, 32'h0, 4'd6},                  // R6
        '{1'b0, 12'h808, 32'h0, 3'd4, 1'b1, 32'h0, 4'd10},                 // R10
        '{1'b1, 12'h008, 32'hFFFF_FFFF, 3'd5, 1'b1, 32'h0, 4'd10},         // R10
        '{1'b0, 12'h802, 32'h0, 3'd4, 1'b1, 32'h0, 4'd10},                 // R10
        '{1'b0, 12'h123, 32'h0, 3'd4, 1'b1, 32'h0, 4'd10},                 // R10
        '{1'b0, 12'h800, 32'h0, 3'd6, 1'b1, 32'h0, 4'd10},                 // R10
        '{1'b0, 12'h800, 32'h0, 3'd0, 1'b1, 32'h0, 4'd2},                  // R2
        '{1'b1, 12'h801, 32'h0000_0005, 3'd0, 1'b1, 32'h0, 4'd2},          // R2
        '{1'b0, 12'h801, 32'h0, 3'd1, 1'b0, 32'h0, 4'd2},                  // R2
        '{1'b1, 12'h801, 32'h0000_0005, 3'd1, 1'b0, 32'h0, 4'd3},          // R3
        '{1'b0, 12'h801, 32'h0, 3'd1, 1'b0, 32'h0000_0005, 4'd3},          // R3
        '{1'b1, 12'h800, 32'h0000_0077, 3'd5, 1'b0, 32'h0, 4'd3},          // R3
        '{1'b0, 12'h800, 32'h0, 3'd3, 1'b0, 32'h0000_0077, 4'd3},          // R3
        '{1'b0, 12'h004, 32'h0, 3'd4, 1'b0, 32'h0, 4'd9},                  // R9
        '{1'b0, 12'h007, 32'h0, 3'd1, 1'b1, 32'h0, 4'd9},                  // R9
        '{1'b1, 12'h002, 32'h1234_5678, 3'd3, 1'b0, 32'h0, 4'd5},          // R5
        '{1'b0, 12'h002, 32'h0, 3'd3, 1'b0, 32'h1234_5678, 4'd5}           // R5
    };

    task automatic chk(input logic ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", rq, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later; a write commits at the next rising edge.
    task automatic access(input logic v, input logic [15:0] op, input logic [11:0] code,
                          input logic [31:0] wd, input logic [2:0] m, input logic e_ill,
                          input logic e_done, input logic [31:0] e_rd, input int rq);
        @(negedge clk);
        acc_valid  = v;
        acc_opcode = op;
        acc_code   = code;
        acc_wdata  = wd;
        cpu_model  = m;
        #1;
        chk(illegal == e_ill,  rq, "illegal", 32'(illegal), 32'(e_ill));
        chk(done == e_done,    rq, "done",    32'(done),    32'(e_done));
        chk(rd_data == e_rd,   rq, "rd_data", rd_data,      e_rd);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid  = 1'b0;
        acc_opcode = 16'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: state after reset
        access(1'b1, 16'h4E7A, 12'h000, 32'h0, 3'd1, 1'b0, 1'b1, 32'h0, 13);
        access(1'b1, 16'h4E7A, 12'h002, 32'h0, 3'd5, 1'b0, 1'b1, 32'h0, 13);

        // Table walk covering R2 to R12
        for (int i = 0; i < NV; i++) begin
            access(1'b1, 16'h4E7A | {15'h0, VEC[i].wr}, VEC[i].code, VEC[i].wd,
                   VEC[i].model, VEC[i].ill, !VEC[i].ill, VEC[i].rd, int'(VEC[i].rq));
        end

        // R1: a foreign opcode carrying a write is ignored
        access(1'b1, 16'h4E7C, 12'h800, 32'hFFFF_FFFF, 3'd5, 1'b0, 1'b0, 32'h0, 1);
        access(1'b1, 16'h4E7A, 12'h800, 32'h0, 3'd5, 1'b0, 1'b1, 32'h77, 1);
        // R1: a move word without valid is ignored
        access(1'b0, 16'h4E7B, 12'h800, 32'hFFFF_FFFF, 3'd5, 1'b0, 1'b0, 32'h0, 1);
        access(1'b1, 16'h4E7A, 12'h800, 32'h0, 3'd5, 1'b0, 1'b1, 32'h77, 1);
        // R12: no read data during a legal write
        access(1'b1, 16'h4E7B, 12'h801, 32'h0000_0009, 3'd2, 1'b0, 1'b1, 32'h0, 12);
        access(1'b1, 16'h4E7A, 12'h801, 32'h0, 3'd2, 1'b0, 1'b1, 32'h9, 12);

        // R13: reset clears previously written registers
        idle();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access(1'b1, 16'h4E7A, 12'h002, 32'h0, 3'd5, 1'b0, 1'b1, 32'h0, 13);
        access(1'b1, 16'h4E7A, 12'h800, 32'h0, 3'd5, 1'b0, 1'b1, 32'h0, 13);
        access(1'b1, 16'h4E7A, 12'h805, 32'h0, 3'd4, 1'b0, 1'b1, 32'h0, 13);
        idle();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule